// File: doc/BRIEF.md
# Ternary Longest-Prefix Route Match Table

This block is a small ternary match table for route lookup. Each entry holds a 32-bit pattern, a per-bit care mask and a valid flag. A search key is compared against every entry at the same time. A care bit of 1 means that bit must equal the key. A care bit of 0 means the bit matches either key value. Among the matching entries, the one with the lowest index wins. Its index then addresses a result memory that holds the egress action for that route.

Software loads one entry at a time through a write port. A write sets the pattern, the care mask, the valid flag and the result word together. Software places prefixes so that longer masks sit at lower indices. With that ordering, the first match is also the longest-prefix match.

A search takes two cycles. In the first cycle the block compares the key and encodes the winner. In the second cycle it reads the result memory. The response then carries a hit flag, the winning index and the 22-bit result word. The result word is {action[1:0], egress[7:0], rewrite[11:0]}. The action codes are 00 forward, 01 punt to the CPU, and 10 drop.

Top module: `tlpm_table`

## Requirements
- R1: A key bit is compared only where the entry's care bit is 1; where the care bit is 0 the key bit may take either value without losing the match.
- R2: An entry whose low five bits are 10000 with care bits 2 and 1 cleared (care = 5'b11001, upper bits don't-care) matches keys ending in 10000, 10010, 10100 and 10110, and does not match keys ending in 10001, 11000 or 01000.
- R3: When several entries match, the response reports the lowest-numbered one.
- R4: With /32, /24, /16 and /8 prefixes stored at indices 0 to 3, each key is answered by the longest prefix that covers it.
- R5: On a hit, rsp_result equals the 22-bit word last written for the winning index, {action[1:0], egress[7:0], rewrite[11:0]}, with action 00 forward, 01 punt, 10 drop.
- R6: When no entry matches, rsp_valid is 1, rsp_hit is 0, rsp_idx is 0 and rsp_result is the default drop word 22'h200000.
- R7: An entry whose valid flag is 0 never matches, even with every care bit cleared; after reset all entries are invalid.
- R8: A search presented with srch_en at clock edge N produces rsp_valid at edge N+2, one response per search, with back-to-back searches answered on consecutive cycles.
- R9: A write at edge N affects searches sampled from edge N+1 onward; a search sampled at edge N still sees the old table.
- R10: While reset is held and whenever rsp_valid is 0, rsp_hit, rsp_idx and rsp_result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one entry this cycle |
| wr_idx | input | IDX_W | Entry index to load |
| wr_valid | input | 1 | Valid flag for the loaded entry |
| wr_value | input | KEY_W | Stored pattern |
| wr_care | input | KEY_W | Per-bit care mask, 1 = compare |
| wr_result | input | 22 | Result word {action, egress, rewrite} |
| srch_en | input | 1 | Start a search with srch_key |
| srch_key | input | KEY_W | Search key |
| rsp_valid | output | 1 | Response present, two cycles after srch_en |
| rsp_hit | output | 1 | At least one entry matched |
| rsp_idx | output | IDX_W | Lowest matching index, 0 on a miss |
| rsp_result | output | 22 | Result word of the winner, or default drop |

## Verification
The assertions assume the write index is always below the entry count. They also assume reset is held for at least two clocks, so the response pipeline is empty when reset is released. The bench only addresses entries 0 to 7 and holds reset for several cycles. The empty-table property depends on the checker's own valid shadow, which follows the write port alone. For that reason the stimulus loads entries only through wr_en and never forces table state.

// File: rtl/tlpm_pkg.sv
package tlpm_pkg;

    localparam int EGRESS_W  = 8;
    localparam int REWRITE_W = 12;

    typedef enum logic [1:0] {
        ACT_FORWARD = 2'b00,
        ACT_PUNT    = 2'b01,
        ACT_DROP    = 2'b10
    } route_act_e;

    typedef struct packed {
        route_act_e             action;
        logic [EGRESS_W-1:0]    egress;
        logic [REWRITE_W-1:0]   rewrite;
    } route_res_t;

    localparam int RES_W = $bits(route_res_t);

    // Returned on a miss: drop, no egress, no rewrite.
    localparam route_res_t MISS_RESULT = '{action: ACT_DROP, egress: '0, rewrite: '0};

endpackage

// File: rtl/tlpm_match_array.sv
// Storage of pattern, care mask and valid flag per entry, plus the
// parallel ternary compare against the search key.
module tlpm_match_array #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 32,
    parameter int IDX_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_valid,
    input  logic [KEY_W-1:0]    wr_value,
    input  logic [KEY_W-1:0]    wr_care,
    input  logic [KEY_W-1:0]    key,
    output logic [ENTRIES-1:0]  match_vec
);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][KEY_W-1:0]  value;
        logic [ENTRIES-1:0][KEY_W-1:0]  care;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (32'(wr_idx) < ENTRIES)) begin
            tbl_d.valid[wr_idx] = wr_valid;
            tbl_d.value[wr_idx] = wr_value;
            tbl_d.care[wr_idx]  = wr_care;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // One comparator per entry: masked XOR must be all zero.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = tbl_q.valid[g] &&
                              (((key ^ tbl_q.value[g]) & tbl_q.care[g]) == '0);
    end

endmodule

// File: rtl/tlpm_prio_enc.sv
// First-match encoder: lowest set bit wins.
module tlpm_prio_enc #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0]  req,
    output logic                any,
    output logic [IDX_W-1:0]    idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlpm_result_mem.sv
// Associated result words, one per entry, asynchronous read.
module tlpm_result_mem #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3,
    parameter int RES_W   = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [RES_W-1:0]    wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [RES_W-1:0]    rd_data
);

    logic [ENTRIES-1:0][RES_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (32'(wr_idx) < ENTRIES)) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/tlpm_table.sv
// Ternary route table: compare + encode in stage 1, result read in stage 2.
module tlpm_table
    import tlpm_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_valid,
    input  logic [KEY_W-1:0]    wr_value,
    input  logic [KEY_W-1:0]    wr_care,
    input  logic [RES_W-1:0]    wr_result,
    input  logic                srch_en,
    input  logic [KEY_W-1:0]    srch_key,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [IDX_W-1:0]    rsp_idx,
    output logic [RES_W-1:0]    rsp_result
);

    typedef struct packed {
        logic               s1_vld;
        logic               s1_hit;
        logic [IDX_W-1:0]   s1_idx;
        logic               s2_vld;
        logic               s2_hit;
        logic [IDX_W-1:0]   s2_idx;
        logic [RES_W-1:0]   s2_res;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [ENTRIES-1:0] match_vec;
    logic               enc_any;
    logic [IDX_W-1:0]   enc_idx;
    logic [RES_W-1:0]   mem_rd;

    tlpm_match_array #(
        .ENTRIES (ENTRIES),
        .KEY_W   (KEY_W),
        .IDX_W   (IDX_W)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_valid  (wr_valid),
        .wr_value  (wr_value),
        .wr_care   (wr_care),
        .key       (srch_key),
        .match_vec (match_vec)
    );

    tlpm_prio_enc #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_enc (
        .req (match_vec),
        .any (enc_any),
        .idx (enc_idx)
    );

    tlpm_result_mem #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .RES_W   (RES_W)
    ) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_result),
        .rd_idx  (pipe_q.s1_idx),
        .rd_data (mem_rd)
    );

    always_comb begin
        pipe_d = pipe_q;

        // Stage 1: capture the encoded winner of this cycle's compare.
        pipe_d.s1_vld = srch_en;
        pipe_d.s1_hit = srch_en && enc_any;
        pipe_d.s1_idx = (srch_en && enc_any) ? enc_idx : '0;

        // Stage 2: read the result word or substitute the miss default.
        pipe_d.s2_vld = pipe_q.s1_vld;
        pipe_d.s2_hit = pipe_q.s1_vld && pipe_q.s1_hit;
        pipe_d.s2_idx = pipe_d.s2_hit ? pipe_q.s1_idx : '0;
        if (!pipe_q.s1_vld) begin
            pipe_d.s2_res = '0;
        end else if (pipe_q.s1_hit) begin
            pipe_d.s2_res = mem_rd;
        end else begin
            pipe_d.s2_res = MISS_RESULT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rsp_valid  = pipe_q.s2_vld;
    assign rsp_hit    = pipe_q.s2_hit;
    assign rsp_idx    = pipe_q.s2_idx;
    assign rsp_result = pipe_q.s2_res;

endmodule

// File: rtl/tlpm_table_chk.sv
module tlpm_table_chk
    import tlpm_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_valid,
    input  logic                srch_en,
    input  logic                rsp_valid,
    input  logic                rsp_hit,
    input  logic [IDX_W-1:0]    rsp_idx,
    input  logic [RES_W-1:0]    rsp_result
);

    // Shadow of valid flags, built from the write port only.
    logic [ENTRIES-1:0] shadow_vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_vld_q <= '0;
        end else if (wr_en && (32'(wr_idx) < ENTRIES)) begin
            shadow_vld_q[wr_idx] <= wr_valid;
        end
    end

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> ##1 rsp_valid);

    assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> ##1 !rsp_valid);

    assert_miss_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_idx == '0 && rsp_result == MISS_RESULT));

    assert_empty_never_hits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_en && shadow_vld_q == '0) |=> ##1 (rsp_valid && !rsp_hit));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_idx == '0 && rsp_result == '0));

endmodule

bind tlpm_table tlpm_table_chk #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_valid   (wr_valid),
    .srch_en    (srch_en),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_idx    (rsp_idx),
    .rsp_result (rsp_result)
);

// File: tb/tlpm_table_bench.sv
module tlpm_table_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_value = '0;
    logic [31:0] wr_care = '0;
    logic [21:0] wr_result = '0;
    logic        srch_en = 1'b0;
    logic [31:0] srch_key = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [2:0]  rsp_idx;
    logic [21:0] rsp_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tlpm_table #(.ENTRIES(8), .KEY_W(32)) u_tlpm_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_valid   (wr_valid),
        .wr_value   (wr_value),
        .wr_care    (wr_care),
        .wr_result  (wr_result),
        .srch_en    (srch_en),
        .srch_key   (srch_key),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_idx    (rsp_idx),
        .rsp_result (rsp_result)
    );

    localparam logic [21:0] MISS = {2'b10, 8'd0, 12'd0};
    localparam logic [21:0] RES0 = {2'b00, 8'd1, 12'h001};
    localparam logic [21:0] RES1 = {2'b00, 8'd2, 12'h002};
    localparam logic [21:0] RES2 = {2'b01, 8'd0, 12'h003};
    localparam logic [21:0] RES3 = {2'b00, 8'd3, 12'h004};
    localparam logic [21:0] RES4 = {2'b10, 8'd5, 12'h0AB};
    localparam logic [21:0] RES7 = {2'b01, 8'd9, 12'h777};

    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] key;
        logic        hit;
        logic [2:0]  idx;
        logic [21:0] res;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{8'd3, 32'h0A010203, 1'b1, 3'd0, RES0},  // R3 all four prefixes match
        '{8'd1, 32'h0A01020F, 1'b1, 3'd1, RES1},  // R1 care bit differs in entry 0
        '{8'd4, 32'h0A0102FF, 1'b1, 3'd1, RES1},  // R4 /24 wins
        '{8'd5, 32'h0A01FF00, 1'b1, 3'd2, RES2},  // R5 punt word
        '{8'd4, 32'h0AFF0000, 1'b1, 3'd3, RES3},  // R4 /8 wins
        '{8'd2, 32'hC0A80010, 1'b1, 3'd4, RES4},  // R2 10000
        '{8'd2, 32'hC0A80012, 1'b1, 3'd4, RES4},  // R2 10010
        '{8'd2, 32'hC0A80014, 1'b1, 3'd4, RES4},  // R2 10100
        '{8'd2, 32'hC0A80016, 1'b1, 3'd4, RES4},  // R2 10110
        '{8'd2, 32'hC0A80011, 1'b0, 3'd0, MISS},  // R2 10001 no match
        '{8'd2, 32'hC0A80018, 1'b0, 3'd0, MISS},  // R2 11000 no match
        '{8'd6, 32'hC0A80008, 1'b0, 3'd0, MISS},  // R6 01000 miss
        '{8'd7, 32'h0B000000, 1'b0, 3'd0, MISS}   // R7 invalid wildcard entry 5
    };

    task automatic check_rsp(input string tag, input logic ev, input logic eh,
                             input logic [2:0] ei, input logic [21:0] er);
        checks++;
        if (rsp_valid !== ev || rsp_hit !== eh || rsp_idx !== ei || rsp_result !== er) begin
            errors++;
            $display("FAIL %s: got v=%0b h=%0b i=%0d r=%h, expected v=%0b h=%0b i=%0d r=%h",
                     tag, rsp_valid, rsp_hit, rsp_idx, rsp_result, ev, eh, ei, er);
        end
    endtask

    task automatic wr_entry(input logic [2:0] idx, input logic vld, input logic [31:0] val,
                            input logic [31:0] care, input logic [21:0] res);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_valid = vld;
        wr_value = val; wr_care = care; wr_result = res;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic search(input logic [31:0] key);
        @(negedge clk);
        srch_en = 1'b1; srch_key = key;
        @(negedge clk);
        srch_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got hung, expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R10: outputs quiet during reset
        repeat (4) @(negedge clk);
        check_rsp("R10 reset", 1'b0, 1'b0, 3'd0, 22'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: empty table after reset, fully wildcard key misses
        search(32'h00000000);
        check_rsp("R7 empty after reset", 1'b1, 1'b0, 3'd0, MISS);

        wr_entry(3'd0, 1'b1, 32'h0A010203, 32'hFFFFFFFF, RES0);
        wr_entry(3'd1, 1'b1, 32'h0A010200, 32'hFFFFFF00, RES1);
        wr_entry(3'd2, 1'b1, 32'h0A010000, 32'hFFFF0000, RES2);
        wr_entry(3'd3, 1'b1, 32'h0A000000, 32'hFF000000, RES3);
        wr_entry(3'd4, 1'b1, 32'h00000010, 32'h00000019, RES4);
        wr_entry(3'd5, 1'b0, 32'h00000000, 32'h00000000, RES7);

        for (int v = 0; v < NVEC; v++) begin
            search(VECS[v].key);
            check_rsp($sformatf("R%0d vector %0d", VECS[v].req, v),
                      1'b1, VECS[v].hit, VECS[v].idx, VECS[v].res);
        end

        // R8: back-to-back searches answered on consecutive cycles
        @(negedge clk);
        srch_en = 1'b1; srch_key = 32'h0A0102FF;
        @(negedge clk);
        srch_key = 32'hC0A80011;
        @(negedge clk);
        check_rsp("R8 first of pair", 1'b1, 1'b1, 3'd1, RES1);
        srch_en = 1'b0;
        @(negedge clk);
        check_rsp("R8 second of pair", 1'b1, 1'b0, 3'd0, MISS);
        @(negedge clk);
        check_rsp("R8 idle after pair", 1'b0, 1'b0, 3'd0, 22'd0);

        // R9: write and search on the same edge, then search the next edge
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd7; wr_valid = 1'b1;
        wr_value = 32'h0; wr_care = 32'h0; wr_result = RES7;
        srch_en = 1'b1; srch_key = 32'h0B000000;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check_rsp("R9 same-edge search sees old table", 1'b1, 1'b0, 3'd0, MISS);
        srch_en = 1'b0;
        @(negedge clk);
        check_rsp("R9 next-edge search sees new entry", 1'b1, 1'b1, 3'd7, RES7);

        // R7: invalidating entry 0 removes it from the match
        wr_entry(3'd0, 1'b0, 32'h0A010203, 32'hFFFFFFFF, RES0);
        search(32'h0A010203);
        check_rsp("R7 invalidated entry skipped", 1'b1, 1'b1, 3'd1, RES1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule